// File: doc/BRIEF.md
# Eight-Channel Input Pulse Counter Bank

This block counts edges on eight digital input lines. Each line has its own 16-bit up counter. The counter takes one count for each edge of the chosen polarity, which can be rising or falling and is set per line. A counter does not restart at zero after its top value. It restarts at a preset that software programs for that line. A second programmable value per line marks a threshold. When a count lands on that threshold, a sticky flag is set. A wrap past the top value sets a separate sticky flag.

A controller drives the block through a command port. Each command is one cycle long and carries an 8-bit opcode and a 16-bit argument. Most commands use the low byte of the argument as a channel mask, so one command updates many channels at once. The commands are enabling counting, reloading counters, choosing edges, and enabling the two interrupt kinds. Two groups of opcodes, indexed by channel, write the preset and threshold values. A readback opcode returns one counter's value as two bytes on consecutive cycles. The inputs are treated as asynchronous, so each one passes through a two-flop synchronizer before edge detection.

Top module: `pulse_cnt_bank`

## Requirements
- R1: After reset, every counter is 0x0000, every preset is 0x0000, every threshold is 0x8000, counting and both interrupt kinds are disabled on all channels, every channel counts rising edges, and all outputs are low.
- R2: Each input is synchronized by two flops. A level change is seen as at most one edge, and a count is taken on the third rising clock edge after the input changes.
- R3: Opcode 0x28 replaces the counting-enable set with mask bits arg[7:0], where bit n is channel n. A disabled channel holds its value, and a zero mask stops all channels.
- R4: Opcode 0x29 loads every masked channel's counter with that channel's preset and clears both of its sticky flags.
- R5: Opcode 0x40+n writes arg[15:0] into channel n's preset, and opcode 0x48+n writes it into channel n's threshold. Neither write changes any counter value.
- R6: Opcode 0x2C sets edge polarity from mask arg[7:0]. Bit n = 0 makes channel n count rising edges, and bit n = 1 makes it count falling edges.
- R7: An enabled channel adds exactly one to its counter for each edge of its selected polarity. The channels count independently and at the same time.
- R8: A count step taken when the counter is at 0xFFFF loads the channel's preset instead of incrementing and sets the channel's sticky overflow flag.
- R9: A count step whose resulting value equals the channel's threshold sets the channel's sticky match flag.
- R10: Opcodes 0x2A and 0x2B replace the per-channel overflow and match interrupt enables from mask arg[7:0]. ovf_irq_o[n] and match_irq_o[n] are high one cycle after the corresponding flag and enable are both set.
- R11: Opcode 0x2F selects channel arg[2:0] and captures that counter's value at the command edge. rd_valid_o is then high for exactly two cycles, starting on the next cycle. rd_byte_o carries the low byte in the first of those cycles and the high byte in the second.
- R12: Opcodes not listed above change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Asynchronous input lines, one per channel |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 8 | Command opcode |
| cmd_arg_i | input | 16 | Command argument (mask, value or channel) |
| rd_valid_o | output | 1 | Readback byte valid |
| rd_byte_o | output | 8 | Readback byte, low byte first then high byte |
| ovf_irq_o | output | NCH | Per-channel overflow interrupt |
| match_irq_o | output | NCH | Per-channel match interrupt |

## Verification
The counting function is tried with every one of the 256 simultaneous pulse masks across the eight inputs. After these pulses each counter must read back its preset plus 128, which separates crosstalk between channels from dropped or doubled counts. Holding an input high with one channel set to rising edges and a neighbour set to falling edges, then releasing it, shows whether the polarity choice is honoured per channel. Presets placed just below 0xFFFF and just below the thresholds move counters across the wrap and match boundaries. Masked and unmasked channels are pulsed together, so a command that reaches the wrong channels shows up in the counts read back.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ARG_W = 16;
  localparam int OP_W  = 8;
  localparam int IDX_W = 3;

  localparam logic [OP_W-1:0] OP_CNT_EN  = 8'h28;
  localparam logic [OP_W-1:0] OP_CNT_LD  = 8'h29;
  localparam logic [OP_W-1:0] OP_OVF_IE  = 8'h2A;
  localparam logic [OP_W-1:0] OP_MAT_IE  = 8'h2B;
  localparam logic [OP_W-1:0] OP_EDGE    = 8'h2C;
  localparam logic [OP_W-1:0] OP_RDBACK  = 8'h2F;
  localparam logic [OP_W-1:0] OP_PRESET  = 8'h40;
  localparam logic [OP_W-1:0] OP_THRESH  = 8'h48;

  typedef struct packed {
    logic             en_wr;
    logic             load;
    logic             ovf_ie_wr;
    logic             mat_ie_wr;
    logic             edge_wr;
    logic             rd;
    logic             pre_wr;
    logic             thr_wr;
    logic [IDX_W-1:0] idx;
  } cmd_dec_t;
endpackage

// File: rtl/pcb_cmd_dec.sv
module pcb_cmd_dec
  import pcb_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output cmd_dec_t        dec_o
);
  always_comb begin
    dec_o     = '0;
    dec_o.idx = op_i[IDX_W-1:0];
    if (valid_i) begin
      case (op_i)
        OP_CNT_EN: dec_o.en_wr     = 1'b1;
        OP_CNT_LD: dec_o.load      = 1'b1;
        OP_OVF_IE: dec_o.ovf_ie_wr = 1'b1;
        OP_MAT_IE: dec_o.mat_ie_wr = 1'b1;
        OP_EDGE:   dec_o.edge_wr   = 1'b1;
        OP_RDBACK: dec_o.rd        = 1'b1;
        default: begin
          if (op_i[OP_W-1:IDX_W] == OP_PRESET[OP_W-1:IDX_W]) dec_o.pre_wr = 1'b1;
          if (op_i[OP_W-1:IDX_W] == OP_THRESH[OP_W-1:IDX_W]) dec_o.thr_wr = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcb_sync_edge.sv
module pcb_sync_edge #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] fall_sel_i,
  output logic [NCH-1:0] ev_o
);
  logic [NCH-1:0] s1_q, s2_q, prev_q;
  logic [NCH-1:0] rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign ev_o[g] = fall_sel_i[g] ? fall[g] : rise[g];

    // R2
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
    // R2
    fall_once_chk: assert property (@(posedge clk) disable iff (rst)
      fall[g] |=> !fall[g]);
  end
endmodule

// File: rtl/pcb_channel.sv
module pcb_channel #(
  parameter int            CW      = 16,
  parameter logic [CW-1:0] PRE_INI = '0,
  parameter logic [CW-1:0] THR_INI = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          load_i,
  input  logic          pre_wr_i,
  input  logic          thr_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          mat_o
);
  logic [CW-1:0] cnt_q, pre_q, thr_q, nxt;
  logic          ovf_q, mat_q, wrap, do_step;

  assign wrap    = (cnt_q == {CW{1'b1}});
  assign nxt     = wrap ? pre_q : cnt_q + 1'b1;
  assign do_step = step_i & ~load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pre_q <= PRE_INI;
      thr_q <= THR_INI;
      ovf_q <= 1'b0;
      mat_q <= 1'b0;
    end else begin
      if (pre_wr_i) pre_q <= wdata_i;
      if (thr_wr_i) thr_q <= wdata_i;
      if (load_i) begin
        cnt_q <= pre_q;
        ovf_q <= 1'b0;
        mat_q <= 1'b0;
      end else if (do_step) begin
        cnt_q <= nxt;
        if (wrap)         ovf_q <= 1'b1;
        if (nxt == thr_q) mat_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign mat_o = mat_q;

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(cnt_q));
  // R7
  cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (do_step && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (do_step && wrap) |=> (ovf_q && cnt_q == $past(pre_q)));
  // R9
  match_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mat_q) |-> $past(do_step));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(pre_q) && !ovf_q && !mat_q));
endmodule

// File: rtl/pulse_cnt_bank.sv
module pulse_cnt_bank
  import pcb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pin_i,
  input  logic             cmd_valid_i,
  input  logic [OP_W-1:0]  cmd_op_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  output logic             rd_valid_o,
  output logic [7:0]       rd_byte_o,
  output logic [NCH-1:0]   ovf_irq_o,
  output logic [NCH-1:0]   match_irq_o
);
  localparam logic [CW-1:0] THR_DEF = CW'(1) << (CW - 1);

  cmd_dec_t       dec;
  logic [NCH-1:0] mask;
  logic [NCH-1:0] cnt_en_q, ovf_ie_q, mat_ie_q, fall_sel_q;
  logic [NCH-1:0] ev, ovf_flag, mat_flag;
  logic [CW-1:0]  cnt_all [NCH];
  logic [CW-1:0]  rd_sel;
  logic           hi_pend_q;
  logic [7:0]     hi_byte_q;

  assign mask = cmd_arg_i[NCH-1:0];

  pcb_cmd_dec u_dec (
    .valid_i (cmd_valid_i),
    .op_i    (cmd_op_i),
    .dec_o   (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en_q   <= '0;
      ovf_ie_q   <= '0;
      mat_ie_q   <= '0;
      fall_sel_q <= '0;
    end else begin
      if (dec.en_wr)     cnt_en_q   <= mask;
      if (dec.ovf_ie_wr) ovf_ie_q   <= mask;
      if (dec.mat_ie_wr) mat_ie_q   <= mask;
      if (dec.edge_wr)   fall_sel_q <= mask;
    end
  end

  pcb_sync_edge #(.NCH(NCH)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (pin_i),
    .fall_sel_i (fall_sel_q),
    .ev_o       (ev)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pcb_channel #(
      .CW      (CW),
      .PRE_INI ('0),
      .THR_INI (THR_DEF)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .step_i   (ev[g] & cnt_en_q[g]),
      .load_i   (dec.load & mask[g]),
      .pre_wr_i (dec.pre_wr && dec.idx == IDX_W'(g)),
      .thr_wr_i (dec.thr_wr && dec.idx == IDX_W'(g)),
      .wdata_i  (cmd_arg_i[CW-1:0]),
      .cnt_o    (cnt_all[g]),
      .ovf_o    (ovf_flag[g]),
      .mat_o    (mat_flag[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (cmd_arg_i[IDX_W-1:0] == IDX_W'(i)) rd_sel = cnt_all[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o  <= 1'b0;
      rd_byte_o   <= '0;
      hi_pend_q   <= 1'b0;
      hi_byte_q   <= '0;
      ovf_irq_o   <= '0;
      match_irq_o <= '0;
    end else begin
      ovf_irq_o   <= ovf_flag & ovf_ie_q;
      match_irq_o <= mat_flag & mat_ie_q;
      if (dec.rd) begin
        rd_valid_o <= 1'b1;
        rd_byte_o  <= rd_sel[7:0];
        hi_byte_q  <= 8'(rd_sel >> 8);
        hi_pend_q  <= 1'b1;
      end else if (hi_pend_q) begin
        rd_valid_o <= 1'b1;
        rd_byte_o  <= hi_byte_q;
        hi_pend_q  <= 1'b0;
      end else begin
        rd_valid_o <= 1'b0;
      end
    end
  end

  // R11
  rd_lo_chk: assert property (@(posedge clk) disable iff (rst)
    dec.rd |=> rd_valid_o);
  // R11
  rd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    dec.rd |-> ##2 rd_valid_o);
  // R10
  ovf_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_irq_o & ~$past(ovf_ie_q)) == '0));
  // R10
  match_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((match_irq_o & ~$past(mat_ie_q)) == '0));
endmodule

// File: tb/pulse_cnt_bank_tb.sv
module pulse_cnt_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [15:0] cmd_arg = '0;
  logic        rd_valid;
  logic [7:0]  rd_byte;
  logic [7:0]  ovf_irq, match_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_cnt [8];
  logic [15:0] pre [8];

  always #10 clk = ~clk;

  pulse_cnt_bank #(.NCH(8), .CW(16)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (pins),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_arg_i   (cmd_arg),
    .rd_valid_o  (rd_valid),
    .rd_byte_o   (rd_byte),
    .ovf_irq_o   (ovf_irq),
    .match_irq_o (match_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic readback(input int ch, input string req, input logic [15:0] exp);
    logic [7:0] lo, hi;
    logic v0, v1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h2F; cmd_arg = 16'(ch);
    @(negedge clk);
    cmd_valid = 1'b0;
    lo = rd_byte; v0 = rd_valid;
    @(negedge clk);
    hi = rd_byte; v1 = rd_valid;
    check({req, " R11 valid"}, {v0, v1}, 2'b11);
    check(req, {hi, lo}, exp);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    pins = pins | m;
    repeat (5) @(negedge clk);
    pins = pins & ~m;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) readback(i, req, exp_cnt[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin exp_cnt[i] = '0; pre[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", rd_valid, 0);
    check("R1 ovf_irq", ovf_irq, 0);
    check("R1 match_irq", match_irq, 0);
    check_all("R1 counters");

    // R12 unknown opcode, R1 counting disabled by default
    cmd(8'h33, 16'hFFFF);
    cmd(8'h50, 16'hFFFF);
    pulse(8'hFF);
    check_all("R12 R1 no count");

    // R3 partial enable
    cmd(8'h28, 16'h000F);
    pulse(8'hFF);
    for (int i = 0; i < 4; i++) exp_cnt[i] = exp_cnt[i] + 1;
    check_all("R3 mask");

    // R5 preset writes do not touch counters
    for (int i = 0; i < 8; i++) begin
      pre[i] = 16'(16'h1111 * i + 3);
      cmd(8'(8'h40 + i), pre[i]);
    end
    check_all("R5 no effect");
    // R4 load all
    cmd(8'h29, 16'h00FF);
    for (int i = 0; i < 8; i++) exp_cnt[i] = pre[i];
    check_all("R4 load");

    // R7 exhaustive sweep of all masks
    cmd(8'h28, 16'h00FF);
    for (int m = 0; m < 256; m++) begin
      pulse(8'(m));
      for (int i = 0; i < 8; i++) if (m[i]) exp_cnt[i] = exp_cnt[i] + 1;
    end
    check_all("R7 sweep");

    // R6 polarity: ch0 falling, ch1 rising
    cmd(8'h2C, 16'h0001);
    @(negedge clk); pins = 8'h03;
    repeat (6) @(negedge clk);
    exp_cnt[1] = exp_cnt[1] + 1;
    readback(0, "R6 fall held", exp_cnt[0]);
    readback(1, "R6 rise held", exp_cnt[1]);
    pins = 8'h00;
    repeat (6) @(negedge clk);
    exp_cnt[0] = exp_cnt[0] + 1;
    readback(0, "R6 fall release", exp_cnt[0]);
    readback(1, "R6 rise release", exp_cnt[1]);
    cmd(8'h2C, 16'h0000);

    // R9 R10 match
    cmd(8'h4A, 16'(exp_cnt[2] + 2));
    cmd(8'h2B, 16'h0004);
    pulse(8'h04);
    check("R9 before threshold", match_irq[2], 0);
    pulse(8'h04);
    check("R9 R10 match irq", match_irq[2], 1);
    cmd(8'h4B, 16'(exp_cnt[3] + 1));
    pulse(8'h08);
    check("R10 masked", match_irq[3], 0);
    cmd(8'h2B, 16'h000C);
    @(negedge clk);
    check("R10 sticky then enabled", match_irq[3:2], 2'b11);
    cmd(8'h29, 16'h000C);
    exp_cnt[2] = pre[2]; exp_cnt[3] = pre[3];
    @(negedge clk);
    check("R4 flags cleared", match_irq[3:2], 2'b00);

    // R8 wrap
    cmd(8'h45, 16'hFFFE);
    cmd(8'h29, 16'h0020);
    cmd(8'h2A, 16'h0020);
    pulse(8'h20);
    readback(5, "R8 at top", 16'hFFFF);
    check("R8 no ovf yet", ovf_irq, 0);
    pulse(8'h20);
    check("R8 R10 ovf irq", ovf_irq, 8'h20);
    readback(5, "R8 reload", 16'hFFFE);

    // R1 default threshold 0x8000
    cmd(8'h46, 16'h7FFE);
    cmd(8'h29, 16'h0040);
    cmd(8'h2B, 16'h0040);
    pulse(8'h40);
    check("R1 below default thr", match_irq[6], 0);
    pulse(8'h40);
    check("R1 default thr", match_irq[6], 1);
    readback(6, "R11 value", 16'h8000);

    // R3 zero mask stops all
    exp_cnt[5] = 16'hFFFE; exp_cnt[6] = 16'h8000;
    cmd(8'h28, 16'h0000);
    pulse(8'hFF);
    check_all("R3 zero mask");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule